// File: doc/BRIEF.md
# Banked Global Compare Timer

This block keeps one 64-bit up-counter that is shared by up to four processor cores. Each core has its own comparator, and that comparator can raise a private interrupt when the shared count reaches the core's programmed value. A single prescaler and a single enable bit govern how fast the counter runs, and any core can program them. The compare value, the auto-increment step, three control bits and the event flag are separate for each core. A core-ID input comes with every register access and selects which core's copy is read or written.

Software programs a compare value and an optional 32-bit step. When the step mode is on, the compare value moves forward by the step on every match. This gives periodic events without any software action between them. The counter is read as two 32-bit halves. Reading the low half captures the high half, so the pair forms one consistent 64-bit value. The counter can be written only while it is stopped.

Top module: `gtimer_bank`

## Requirements
- R1: After reset the counter, the shared enable and prescaler, and every core's compare value, step, control bits and status flag are zero, and all interrupt outputs are low.
- R2: Control register at offset 0x08: bit 0 is the shared enable and bits [15:8] are the shared prescaler. A write from any core updates both for all cores. A read returns the shared fields together with the requesting core's bits [3:1]. Bits [7:4] and [31:16] read as zero.
- R3: Control bit 1 (compare enable), bit 2 (interrupt enable) and bit 3 (step enable) are held separately for each core. Writes to control, compare (0x10, 0x14) and step (0x18) change only the requesting core's copy.
- R4: While enabled with prescaler value P, the counter advances by one every P+1 clock cycles, and the carry passes from the low half into the high half. While disabled, the counter holds its value.
- R5: Writes to counter low (0x00) or counter high (0x04) load that half only while the timer is disabled. While it is enabled they are ignored.
- R6: A read of 0x00 returns the low half and captures the current high half. A read of 0x04 returns that captured value.
- R7: When the counter advances to a value equal to a core's compare value, with the shared enable and that core's compare enable set, a match occurs. If the core's interrupt enable is also set, its status flag (bit 0 of 0x0C) becomes 1. Without interrupt enable the flag stays 0.
- R8: On a match with step enable set, the core's compare value grows by its 32-bit step, so that the next match comes that many counts later.
- R9: Writing 1 to bit 0 of 0x0C clears the requesting core's status flag. Writing 0 leaves the flag unchanged. Otherwise the flag stays set until it is cleared.
- R10: Each core's interrupt output is a level equal to its status flag ANDed with its interrupt enable.
- R11: Compare low (0x10) and compare high (0x14) each replace only their own 32 bits. Reads of offsets outside the map return zero. Only the low 8 address bits are decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | 2 | ID of the requesting core, selects the banked copy |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current access (combinational) |
| irq_o | output | 4 | Level interrupt, one per core |

## Verification
The bench builds the block with its default parameters: four cores, a 64-bit counter and an 8-bit prescaler. With all four banks present, a write from one core can be checked for leaks into the others, and the shared control fields can be checked as seen from a different core. The counter is preloaded just below the 32-bit boundary so that the carry into the high half happens within a few cycles. Prescaler values of 0, 2 and 255 cover single-cycle ticks, a divided rate, and a window in which no tick can occur.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [7:0] {
        OFF_CNT_LO = 8'h00,
        OFF_CNT_HI = 8'h04,
        OFF_CTRL   = 8'h08,
        OFF_STAT   = 8'h0C,
        OFF_CMP_LO = 8'h10,
        OFF_CMP_HI = 8'h14,
        OFF_STEP   = 8'h18
    } reg_off_e;
endpackage

// File: rtl/gtimer_count.sv
module gtimer_count #(
    parameter int CNT_W   = 64,
    parameter int PRESC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [PRESC_W-1:0]   presc,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [CNT_W/2-1:0]   wdata,
    output logic [CNT_W-1:0]     cnt,
    output logic                 tick
);
    localparam int HALF = CNT_W / 2;

    typedef struct packed {
        logic [PRESC_W-1:0] pcnt;
        logic [CNT_W-1:0]   cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = en && (st_q.pcnt == presc);
        if (!en || tick) st_d.pcnt = '0;
        else             st_d.pcnt = st_q.pcnt + PRESC_W'(1);
        if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        if (!en) begin
            if (wr_lo) st_d.cnt[HALF-1:0]     = wdata;
            if (wr_hi) st_d.cnt[CNT_W-1:HALF] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R4: a stopped counter with no load holds its value
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_lo && !wr_hi) |=> $stable(st_q.cnt));
    // R4: a running counter moves by at most one per cycle
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));
    // R5: loads are ignored while running
    a_r5_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(st_q.cnt));
endmodule

// File: rtl/gtimer_slot.sv
module gtimer_slot
    import gtimer_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int STEP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               glob_en,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               sel,
    input  logic               wr,
    input  logic [7:0]         off,
    input  logic [WORD_W-1:0]  wdata,
    output logic [2:0]         ctl_bits,
    output logic [CNT_W-1:0]   cmp,
    output logic [STEP_W-1:0]  step,
    output logic               status,
    output logic               irq
);
    typedef struct packed {
        logic               cmp_en;
        logic               int_en;
        logic               step_en;
        logic [CNT_W-1:0]   cmp;
        logic [STEP_W-1:0]  step;
        logic               status;
    } slot_state_t;

    slot_state_t sl_d, sl_q;
    logic hit, clr, cmp_wr;

    always_comb begin
        sl_d   = sl_q;
        hit    = glob_en && tick && sl_q.cmp_en && ((cnt + CNT_W'(1)) == sl_q.cmp);
        clr    = sel && wr && (off == OFF_STAT) && wdata[0];
        cmp_wr = sel && wr && ((off == OFF_CMP_LO) || (off == OFF_CMP_HI));
        if (hit && sl_q.step_en) sl_d.cmp = sl_q.cmp + CNT_W'(sl_q.step);
        if (clr) sl_d.status = 1'b0;
        if (hit && sl_q.int_en) sl_d.status = 1'b1;
        if (sel && wr) begin
            case (off)
                OFF_CTRL: begin
                    sl_d.cmp_en  = wdata[1];
                    sl_d.int_en  = wdata[2];
                    sl_d.step_en = wdata[3];
                end
                OFF_CMP_LO: sl_d.cmp[WORD_W-1:0]     = wdata;
                OFF_CMP_HI: sl_d.cmp[CNT_W-1:WORD_W] = wdata;
                OFF_STEP:   sl_d.step                = wdata[STEP_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign ctl_bits = {sl_q.step_en, sl_q.int_en, sl_q.cmp_en};
    assign cmp      = sl_q.cmp;
    assign step     = sl_q.step;
    assign status   = sl_q.status;
    assign irq      = sl_q.status & sl_q.int_en;

    // R7: the flag cannot rise while interrupts are disabled for this core
    a_r7_needs_int_en: assert property (@(posedge clk) disable iff (!rst_n)
        (!sl_q.status && !sl_q.int_en) |=> !sl_q.status);
    // R9: the flag is sticky until a clear is written
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_q.status && !clr) |=> sl_q.status);
    // R8: the compare value moves only on a write or a match
    a_r8_cmp_moves_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !cmp_wr) |=> $stable(sl_q.cmp));
endmodule

// File: rtl/gtimer_bank.sv
module gtimer_bank
    import gtimer_pkg::*;
#(
    parameter int NCORES  = 4,
    parameter int CNT_W   = 64,
    parameter int PRESC_W = 8,
    parameter int STEP_W  = 32,
    localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CORE_W-1:0]  req_core,
    input  logic [7:0]         req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic [NCORES-1:0]  irq_o
);
    typedef struct packed {
        logic                en;
        logic [PRESC_W-1:0]  presc;
        logic [WORD_W-1:0]   hi_shadow;
    } glob_state_t;

    glob_state_t gl_d, gl_q;

    logic               wr_acc, rd_acc, tick;
    logic [CNT_W-1:0]   cnt;
    logic [2:0]         ctl_a  [NCORES];
    logic [CNT_W-1:0]   cmp_a  [NCORES];
    logic [STEP_W-1:0]  step_a [NCORES];
    logic [NCORES-1:0]  stat_a;

    assign wr_acc = req_valid && req_write;
    assign rd_acc = req_valid && !req_write;

    gtimer_count #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (gl_q.en),
        .presc (gl_q.presc),
        .wr_lo (wr_acc && (req_addr == OFF_CNT_LO)),
        .wr_hi (wr_acc && (req_addr == OFF_CNT_HI)),
        .wdata (req_wdata),
        .cnt   (cnt),
        .tick  (tick)
    );

    for (genvar c = 0; c < NCORES; c++) begin : g_slot
        gtimer_slot #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .glob_en  (gl_q.en),
            .cnt      (cnt),
            .sel      (req_valid && (req_core == CORE_W'(c))),
            .wr       (req_write),
            .off      (req_addr),
            .wdata    (req_wdata),
            .ctl_bits (ctl_a[c]),
            .cmp      (cmp_a[c]),
            .step     (step_a[c]),
            .status   (stat_a[c]),
            .irq      (irq_o[c])
        );
    end

    always_comb begin
        gl_d = gl_q;
        if (wr_acc && (req_addr == OFF_CTRL)) begin
            gl_d.en    = req_wdata[0];
            gl_d.presc = req_wdata[8 +: PRESC_W];
        end
        if (rd_acc && (req_addr == OFF_CNT_LO)) gl_d.hi_shadow = cnt[CNT_W-1:WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gl_q <= '0;
        else        gl_q <= gl_d;
    end

    always_comb begin
        rsp_rdata = '0;
        case (req_addr)
            OFF_CNT_LO: rsp_rdata = cnt[WORD_W-1:0];
            OFF_CNT_HI: rsp_rdata = gl_q.hi_shadow;
            OFF_CTRL:   rsp_rdata = {16'b0, gl_q.presc, 4'b0, ctl_a[req_core], gl_q.en};
            OFF_STAT:   rsp_rdata = {31'b0, stat_a[req_core]};
            OFF_CMP_LO: rsp_rdata = cmp_a[req_core][WORD_W-1:0];
            OFF_CMP_HI: rsp_rdata = cmp_a[req_core][CNT_W-1:WORD_W];
            OFF_STEP:   rsp_rdata = WORD_W'(step_a[req_core]);
            default:    rsp_rdata = '0;
        endcase
    end

    // R6: the captured high half changes only on a low-half read
    a_r6_shadow_on_lo_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_acc && (req_addr == OFF_CNT_LO)) |=> $stable(gl_q.hi_shadow));
    // R2: shared control changes only through a control write
    a_r2_shared_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && (req_addr == OFF_CTRL)) |=> ($stable(gl_q.en) && $stable(gl_q.presc)));
endmodule

// File: tb/gtimer_bank_bench.sv
module gtimer_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_core = '0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [3:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] got;

    always #5 clk = ~clk;

    gtimer_bank u_gtimer_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    // {core[73:72], addr[71:64], wdata[63:32], expected readback[31:0]}
    localparam logic [73:0] VEC [8] = '{
        {2'd0, 8'h10, 32'h1234_5678, 32'h1234_5678},   // R11
        {2'd0, 8'h14, 32'hCAFE_F00D, 32'hCAFE_F00D},   // R11
        {2'd1, 8'h10, 32'h0000_0011, 32'h0000_0011},   // R3
        {2'd2, 8'h18, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R3
        {2'd3, 8'h08, 32'hFFFF_FFFE, 32'h0000_FF0E},   // R2
        {2'd0, 8'h08, 32'h0000_0A04, 32'h0000_0A04},   // R2
        {2'd1, 8'h1C, 32'h0000_0005, 32'h0000_0000},   // R11
        {2'd0, 8'h14, 32'h0000_0001, 32'h0000_0001}    // R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] c, input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_core = c; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] c, input logic [7:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_core = c; req_addr = a;
        #1 d = rsp_rdata;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        rd(2'd0, 8'h08, got); chk("R1 ctrl", got, 32'h0);
        rd(2'd1, 8'h10, got); chk("R1 cmp lo", got, 32'h0);
        rd(2'd2, 8'h18, got); chk("R1 step", got, 32'h0);
        rd(2'd3, 8'h0C, got); chk("R1 status", got, 32'h0);
        rd(2'd0, 8'h00, got); chk("R1 cnt lo", got, 32'h0);
        chk("R1 irq", {28'h0, irq_o}, 32'h0);

        // register table: write then read back on the same core
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][73:72], VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][73:72], VEC[i][71:64], got);
            chk("R2/R3/R11 table", got, VEC[i][31:0]);
        end
        rd(2'd0, 8'h10, got); chk("R3 core0 cmp untouched by core1", got, 32'h1234_5678);
        rd(2'd0, 8'h14, got); chk("R11 low write kept high half", got, 32'h0000_0001);
        rd(2'd3, 8'h08, got); chk("R2 shared presc seen by core3", got, 32'h0000_0A0E);
        rd(2'd2, 8'h10, got); chk("R3 core2 cmp still zero", got, 32'h0);

        // R4 carry, R6 capture
        do_reset();
        wr(2'd0, 8'h00, 32'hFFFF_FFFE);
        wr(2'd0, 8'h04, 32'h0000_0007);
        wr(2'd0, 8'h08, 32'h0000_0001);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h08, 32'h0000_0000);
        rd(2'd0, 8'h00, got); chk("R4 carry lo", got, 32'h0000_0002);
        rd(2'd0, 8'h04, got); chk("R4 R6 carry hi", got, 32'h0000_0008);
        wr(2'd0, 8'h04, 32'h0000_0055);
        rd(2'd0, 8'h04, got); chk("R6 hi read returns captured value", got, 32'h0000_0008);
        rd(2'd0, 8'h00, got);
        rd(2'd0, 8'h04, got); chk("R6 recapture after lo read", got, 32'h0000_0055);

        // R4 prescaler 2
        wr(2'd0, 8'h00, 32'h0);
        wr(2'd0, 8'h08, 32'h0000_0201);
        repeat (8) @(negedge clk);
        wr(2'd0, 8'h08, 32'h0000_0000);
        rd(2'd0, 8'h00, got); chk("R4 prescaled count", got, 32'h0000_0003);
        // R5 load ignored while running
        wr(2'd0, 8'h08, 32'h0000_FF01);
        wr(2'd0, 8'h00, 32'h0000_0077);
        wr(2'd0, 8'h08, 32'h0000_0000);
        rd(2'd0, 8'h00, got); chk("R5 load ignored when enabled", got, 32'h0000_0003);
        repeat (3) @(negedge clk);
        rd(2'd0, 8'h00, got); chk("R4 holds when disabled", got, 32'h0000_0003);

        // R7 / R10 match
        do_reset();
        wr(2'd0, 8'h10, 32'd5);
        wr(2'd0, 8'h08, 32'h6);
        wr(2'd1, 8'h10, 32'd5);
        wr(2'd1, 8'h08, 32'h2);
        wr(2'd2, 8'h08, 32'h1);
        repeat (4) @(negedge clk);
        chk("R7 no early event", {28'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R7 R10 irq on match core0 only", {28'h0, irq_o}, 32'h1);
        wr(2'd2, 8'h08, 32'h0);
        rd(2'd0, 8'h0C, got); chk("R7 status core0", got, 32'h1);
        rd(2'd1, 8'h0C, got); chk("R7 no status without int enable", got, 32'h0);
        wr(2'd0, 8'h08, 32'h2);
        chk("R10 irq follows int enable", {28'h0, irq_o}, 32'h0);
        rd(2'd0, 8'h0C, got); chk("R10 flag kept while masked", got, 32'h1);
        wr(2'd0, 8'h08, 32'h6);
        chk("R10 irq back on", {28'h0, irq_o}, 32'h1);
        // R9 clear
        wr(2'd0, 8'h0C, 32'h0);
        rd(2'd0, 8'h0C, got); chk("R9 write 0 no effect", got, 32'h1);
        wr(2'd0, 8'h0C, 32'h1);
        rd(2'd0, 8'h0C, got); chk("R9 write 1 clears", got, 32'h0);
        chk("R9 irq low after clear", {28'h0, irq_o}, 32'h0);

        // R8 auto-increment
        do_reset();
        wr(2'd1, 8'h10, 32'd3);
        wr(2'd1, 8'h18, 32'd4);
        wr(2'd1, 8'h08, 32'hF);
        repeat (8) @(negedge clk);
        wr(2'd1, 8'h08, 32'hE);
        rd(2'd1, 8'h10, got); chk("R8 compare advanced twice", got, 32'd11);
        rd(2'd1, 8'h0C, got); chk("R8 status set", got, 32'h1);
        rd(2'd0, 8'h00, got); chk("R8 count at stop", got, 32'd9);
        chk("R8 irq core1", {28'h0, irq_o}, 32'h2);

        finish_run();
    end
endmodule